// File: doc/BRIEF.md
# Bus Address Decoder with Boot Remap

This block is the first decode stage on one bus master's address path. Each cycle it takes a 32-bit address and a valid strobe and, through combinational logic only, raises exactly one of the following: a slave select for the internal ROM, a select for one of two internal SRAM banks, one of the external chip selects, the peripheral bridge select, or an abort. The top four address bits pick one of sixteen 256 MB banks. Bank 0 then goes through a second decode level, split into 1 MB regions, which places each internal memory at a fixed base.

The lowest 1 MB region of bank 0 is an alias whose target can change. While reset is held, a boot-mode pin is captured into a register. A remap bit, which software writes through an enabled write port, overrides that captured value. Together they decide whether the zero window reaches the ROM, external chip select 0 or SRAM0. When the zero window is aliased to an internal memory, it keeps that memory's size limit. The internal memories can still be reached at their own bases in every mode.

Top module: `addr_bank_decoder`

## Requirements
- R1: With valid high, address bits [31:28] equal to n with 1 <= n <= 7 raise only sel_ext_o[n].
- R2: With valid high, bank 15 (address bits [31:28] = 4'hF) raises only sel_periph_o.
- R3: With valid high, banks 8 to 14 raise only abort_o.
- R4: Inside bank 0, address bits [27:20] pick a 1 MB region. Region 1 is the ROM (sel_rom_o) for offsets below 32 KB. Region 2 is SRAM0 (sel_sram_o[0]) and region 3 is SRAM1 (sel_sram_o[1]), each for offsets below 4 KB. Every other offset in regions 1 to 3, and every access to regions 4 to 255, raises abort_o. This holds in every boot and remap mode.
- R5: With the remap bit at 0 and the captured boot level at 1, region 0 reaches the ROM for offsets below 32 KB and aborts above that.
- R6: With the remap bit at 0 and the captured boot level at 0, every offset in region 0 raises sel_ext_o[0].
- R7: With the remap bit at 1, region 0 reaches SRAM0 for offsets below 4 KB and aborts above that, whatever the boot level.
- R8: The boot-mode pin is sampled only on clock edges while rst_n is low. Changes to it after reset leave the decode unchanged.
- R9: Reset clears the remap bit. A write with remap_we_i high loads remap_wdata_i, and the new value steers decode from the next cycle on. With remap_we_i low, remap_wdata_i has no effect.
- R10: With req_valid_i low, every select output and abort_o are low.
- R11: With req_valid_i high, exactly one of the select and abort outputs is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boot_sel_i | input | 1 | Boot-mode level, captured while reset is held |
| remap_we_i | input | 1 | Write enable for the remap bit |
| remap_wdata_i | input | 1 | Value written to the remap bit |
| req_valid_i | input | 1 | Address valid strobe |
| req_addr_i | input | 32 | Request address |
| sel_rom_o | output | 1 | Internal ROM select |
| sel_sram_o | output | 2 | Internal SRAM bank selects |
| sel_ext_o | output | 8 | External chip selects |
| sel_periph_o | output | 1 | Peripheral bridge select |
| abort_o | output | 1 | Access to an unmapped location |

## Verification
The block holds only two bits of state: the captured boot level and the remap bit. A wrong value in either one appears at the ports only when an access lands in region 0 of bank 0. The bench therefore probes the zero window right after every reset, right after every remap write, and after writes sent with the enable low. A stale or wrongly captured bit then shows up in the same cycle as the next such access, as the wrong select or as a missing or extra abort. Random addresses weighted toward bank 0 compare every other path against a model of the address map.

// File: rtl/adec_pkg.sv
package adec_pkg;

   // Target of the zero window, chosen by boot level and remap bit
   typedef enum logic [1:0] {
      ALIAS_ROM   = 2'd0,
      ALIAS_EXT0  = 2'd1,
      ALIAS_SRAM0 = 2'd2
   } alias_tgt_e;

   // Result of the second-level (bank 0) decode
   typedef enum logic [2:0] {
      IT_ROM   = 3'd0,
      IT_SRAM0 = 3'd1,
      IT_SRAM1 = 3'd2,
      IT_EXT0  = 3'd3,
      IT_ABORT = 3'd4
   } int_tgt_e;

endpackage

// File: rtl/adec_remap_ctl.sv
module adec_remap_ctl
   import adec_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       boot_pin,
   input  logic       wr_en,
   input  logic       wr_data,
   output alias_tgt_e alias_o
);

   logic remap_q;
   logic boot_q;

   // Remap bit: cleared by reset, written by software
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     remap_q <= 1'b0;
      else if (wr_en) remap_q <= wr_data;
   end

   // Boot level: follows the pin only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) boot_q <= boot_pin;
   end

   always_comb begin
      if (remap_q)     alias_o = ALIAS_SRAM0;
      else if (boot_q) alias_o = ALIAS_ROM;
      else             alias_o = ALIAS_EXT0;
   end

endmodule

// File: rtl/adec_bank_dec.sv
module adec_bank_dec #(
   parameter int BANK_W      = 4,
   parameter int EXT_N       = 8,
   parameter int PERIPH_BANK = 15
) (
   input  logic [BANK_W-1:0] bank_i,
   output logic              bank0_o,
   output logic [EXT_N-1:0]  ext_o,
   output logic              periph_o,
   output logic              unused_o
);

   localparam int NBANKS = 1 << BANK_W;

   logic [NBANKS-1:0] bank_hit;

   // One compare per bank
   for (genvar b = 0; b < NBANKS; b++) begin : g_hit
      assign bank_hit[b] = (bank_i == BANK_W'(b));
   end

   assign bank0_o  = bank_hit[0];
   assign periph_o = bank_hit[PERIPH_BANK];

   // Bank 0 never drives chip select 0 directly; only the alias does
   assign ext_o[0] = 1'b0;
   for (genvar c = 1; c < EXT_N; c++) begin : g_ext
      assign ext_o[c] = bank_hit[c];
   end

   // Banks that belong to nothing
   always_comb begin
      unused_o = 1'b1;
      for (int b = 0; b < EXT_N; b++) begin
         if (bank_hit[b]) unused_o = 1'b0;
      end
      if (bank_hit[PERIPH_BANK]) unused_o = 1'b0;
   end

endmodule

// File: rtl/adec_int_dec.sv
module adec_int_dec
   import adec_pkg::*;
#(
   parameter int RIDX_W       = 8,
   parameter int OFF_W        = 20,
   parameter int ROM_BYTES    = 32768,
   parameter int SRAM_BYTES   = 4096,
   parameter int ROM_REGION   = 1,
   parameter int SRAM0_REGION = 2,
   parameter int SRAM1_REGION = 3
) (
   input  logic [RIDX_W-1:0] ridx_i,
   input  logic [OFF_W-1:0]  off_i,
   input  alias_tgt_e        alias_i,
   output int_tgt_e          tgt_o
);

   localparam int ROM_AW  = $clog2(ROM_BYTES);
   localparam int SRAM_AW = $clog2(SRAM_BYTES);

   logic rom_fit;
   logic sram_fit;

   // Offset fits the device when all bits above its size are zero
   if (ROM_AW < OFF_W) begin : g_rom_lim
      assign rom_fit = (off_i[OFF_W-1:ROM_AW] == '0);
   end else begin : g_rom_full
      assign rom_fit = 1'b1;
   end

   if (SRAM_AW < OFF_W) begin : g_sram_lim
      assign sram_fit = (off_i[OFF_W-1:SRAM_AW] == '0);
   end else begin : g_sram_full
      assign sram_fit = 1'b1;
   end

   always_comb begin
      tgt_o = IT_ABORT;
      if (ridx_i == '0) begin
         unique case (alias_i)
            ALIAS_ROM:   tgt_o = rom_fit  ? IT_ROM   : IT_ABORT;
            ALIAS_SRAM0: tgt_o = sram_fit ? IT_SRAM0 : IT_ABORT;
            default:     tgt_o = IT_EXT0;
         endcase
      end else if (ridx_i == RIDX_W'(ROM_REGION)) begin
         tgt_o = rom_fit ? IT_ROM : IT_ABORT;
      end else if (ridx_i == RIDX_W'(SRAM0_REGION)) begin
         tgt_o = sram_fit ? IT_SRAM0 : IT_ABORT;
      end else if (ridx_i == RIDX_W'(SRAM1_REGION)) begin
         tgt_o = sram_fit ? IT_SRAM1 : IT_ABORT;
      end
   end

endmodule

// File: rtl/addr_bank_decoder.sv
module addr_bank_decoder
   import adec_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int BANK_W       = 4,
   parameter int OFF_W        = 20,
   parameter int EXT_N        = 8,
   parameter int PERIPH_BANK  = 15,
   parameter int ROM_BYTES    = 32768,
   parameter int SRAM_BYTES   = 4096,
   parameter int ROM_REGION   = 1,
   parameter int SRAM0_REGION = 2,
   parameter int SRAM1_REGION = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boot_sel_i,
   input  logic              remap_we_i,
   input  logic              remap_wdata_i,
   input  logic              req_valid_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   output logic              sel_rom_o,
   output logic [1:0]        sel_sram_o,
   output logic [EXT_N-1:0]  sel_ext_o,
   output logic              sel_periph_o,
   output logic              abort_o
);

   localparam int RIDX_W = ADDR_W - BANK_W - OFF_W;

   // Elaboration-time parameter checks
   if (RIDX_W < 2) begin : g_bad_split
      $error("addr_bank_decoder: address too narrow for bank and region split");
   end
   if (EXT_N < 2 || EXT_N > PERIPH_BANK) begin : g_bad_ext
      $error("addr_bank_decoder: EXT_N must lie in 2..PERIPH_BANK");
   end
   if (PERIPH_BANK >= (1 << BANK_W)) begin : g_bad_periph
      $error("addr_bank_decoder: PERIPH_BANK outside bank range");
   end
   if ($clog2(ROM_BYTES) > OFF_W || $clog2(SRAM_BYTES) > OFF_W) begin : g_bad_size
      $error("addr_bank_decoder: memory larger than one region");
   end
   if (ROM_REGION == 0 || SRAM0_REGION == 0 || SRAM1_REGION == 0 ||
       ROM_REGION == SRAM0_REGION || ROM_REGION == SRAM1_REGION ||
       SRAM0_REGION == SRAM1_REGION) begin : g_bad_region
      $error("addr_bank_decoder: fixed regions must be distinct and nonzero");
   end

   logic [BANK_W-1:0] bank;
   logic [RIDX_W-1:0] ridx;
   logic [OFF_W-1:0]  off;
   alias_tgt_e        alias_tgt;
   int_tgt_e          int_tgt;
   logic              bank0;
   logic [EXT_N-1:0]  ext_bank;
   logic              periph_hit;
   logic              unused_hit;

   assign bank = req_addr_i[ADDR_W-1 -: BANK_W];
   assign ridx = req_addr_i[OFF_W +: RIDX_W];
   assign off  = req_addr_i[OFF_W-1:0];

   adec_remap_ctl u_remap (
      .clk      (clk),
      .rst_n    (rst_n),
      .boot_pin (boot_sel_i),
      .wr_en    (remap_we_i),
      .wr_data  (remap_wdata_i),
      .alias_o  (alias_tgt)
   );

   adec_bank_dec #(
      .BANK_W      (BANK_W),
      .EXT_N       (EXT_N),
      .PERIPH_BANK (PERIPH_BANK)
   ) u_bank (
      .bank_i   (bank),
      .bank0_o  (bank0),
      .ext_o    (ext_bank),
      .periph_o (periph_hit),
      .unused_o (unused_hit)
   );

   adec_int_dec #(
      .RIDX_W       (RIDX_W),
      .OFF_W        (OFF_W),
      .ROM_BYTES    (ROM_BYTES),
      .SRAM_BYTES   (SRAM_BYTES),
      .ROM_REGION   (ROM_REGION),
      .SRAM0_REGION (SRAM0_REGION),
      .SRAM1_REGION (SRAM1_REGION)
   ) u_int (
      .ridx_i  (ridx),
      .off_i   (off),
      .alias_i (alias_tgt),
      .tgt_o   (int_tgt)
   );

   logic int_go;
   assign int_go = req_valid_i & bank0;

   always_comb begin
      sel_rom_o     = int_go & (int_tgt == IT_ROM);
      sel_sram_o[0] = int_go & (int_tgt == IT_SRAM0);
      sel_sram_o[1] = int_go & (int_tgt == IT_SRAM1);
      sel_ext_o     = req_valid_i ? ext_bank : '0;
      sel_ext_o[0]  = int_go & (int_tgt == IT_EXT0);
      sel_periph_o  = req_valid_i & periph_hit;
      abort_o       = req_valid_i & (unused_hit | (bank0 & (int_tgt == IT_ABORT)));
   end

endmodule

// File: rtl/adec_checks.sv
module adec_checks #(
   parameter int ADDR_W      = 32,
   parameter int BANK_W      = 4,
   parameter int OFF_W       = 20,
   parameter int EXT_N       = 8,
   parameter int PERIPH_BANK = 15,
   parameter int ROM_BYTES   = 32768,
   parameter int SRAM_BYTES  = 4096,
   parameter int ROM_REGION  = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              remap_we_i,
   input logic              remap_wdata_i,
   input logic              req_valid_i,
   input logic [ADDR_W-1:0] req_addr_i,
   input logic              sel_rom_o,
   input logic [1:0]        sel_sram_o,
   input logic [EXT_N-1:0]  sel_ext_o,
   input logic              sel_periph_o,
   input logic              abort_o
);

   localparam int RIDX_W = ADDR_W - BANK_W - OFF_W;

   logic [BANK_W-1:0] bank;
   logic [RIDX_W-1:0] ridx;
   logic [OFF_W-1:0]  off;
   logic [EXT_N+4:0]  all_sel;

   assign bank    = req_addr_i[ADDR_W-1 -: BANK_W];
   assign ridx    = req_addr_i[OFF_W +: RIDX_W];
   assign off     = req_addr_i[OFF_W-1:0];
   assign all_sel = {abort_o, sel_periph_o, sel_ext_o, sel_sram_o, sel_rom_o};

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid_i |-> all_sel == '0);                                   // R10

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i |-> $countones(all_sel) == 1);                         // R11

   AST_EXT_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i && bank != '0 && int'(bank) < EXT_N
      |-> sel_ext_o == (EXT_N'(1) << bank));                             // R1

   AST_PERIPH_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i && int'(bank) == PERIPH_BANK |-> sel_periph_o);        // R2

   AST_HOLE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i && int'(bank) >= EXT_N && int'(bank) != PERIPH_BANK
      |-> abort_o);                                                      // R3

   AST_ROM_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i && bank == '0 && int'(ridx) == ROM_REGION
      && int'(off) < ROM_BYTES |-> sel_rom_o);                           // R4

   AST_REMAP_SRAM0: assert property (@(posedge clk) disable iff (!rst_n)
      $past(remap_we_i && remap_wdata_i) && req_valid_i && bank == '0
      && ridx == '0 && int'(off) < SRAM_BYTES |-> sel_sram_o[0]);        // R7

endmodule

bind addr_bank_decoder adec_checks #(
   .ADDR_W      (ADDR_W),
   .BANK_W      (BANK_W),
   .OFF_W       (OFF_W),
   .EXT_N       (EXT_N),
   .PERIPH_BANK (PERIPH_BANK),
   .ROM_BYTES   (ROM_BYTES),
   .SRAM_BYTES  (SRAM_BYTES),
   .ROM_REGION  (ROM_REGION)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .remap_we_i    (remap_we_i),
   .remap_wdata_i (remap_wdata_i),
   .req_valid_i   (req_valid_i),
   .req_addr_i    (req_addr_i),
   .sel_rom_o     (sel_rom_o),
   .sel_sram_o    (sel_sram_o),
   .sel_ext_o     (sel_ext_o),
   .sel_periph_o  (sel_periph_o),
   .abort_o       (abort_o)
);

// File: tb/sim_addr_bank_decoder.sv
`timescale 1ns/1ps
module sim_addr_bank_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boot_sel = 1'b1;
   logic        we = 1'b0;
   logic        wd = 1'b0;
   logic        valid = 1'b0;
   logic [31:0] addr = '0;
   logic        sel_rom;
   logic [1:0]  sel_sram;
   logic [7:0]  sel_ext;
   logic        sel_periph;
   logic        abort_s;

   int n_checks = 0;
   int n_fail   = 0;
   logic m_remap = 1'b0;
   logic m_boot  = 1'b1;

   always #4 clk = ~clk;

   addr_bank_decoder u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .boot_sel_i    (boot_sel),
      .remap_we_i    (we),
      .remap_wdata_i (wd),
      .req_valid_i   (valid),
      .req_addr_i    (addr),
      .sel_rom_o     (sel_rom),
      .sel_sram_o    (sel_sram),
      .sel_ext_o     (sel_ext),
      .sel_periph_o  (sel_periph),
      .abort_o       (abort_s)
   );

   // Packed result: [0] rom, [2:1] sram, [10:3] ext, [11] periph, [12] abort
   localparam logic [12:0] E_ROM = 13'h0001;
   localparam logic [12:0] E_S0  = 13'h0002;
   localparam logic [12:0] E_S1  = 13'h0004;
   localparam logic [12:0] E_AB  = 13'h1000;
   localparam logic [12:0] E_PER = 13'h0800;

   function automatic logic [12:0] e_ext(input int n);
      return 13'(13'h0008 << n);
   endfunction

   function automatic logic [12:0] model(input logic v, input logic [31:0] a,
                                         input logic rm, input logic bt);
      logic [3:0]  bk;
      logic [7:0]  ri;
      logic [19:0] of;
      bk = a[31:28]; ri = a[27:20]; of = a[19:0];
      if (!v) return '0;
      if (bk == 4'd0) begin
         if (ri == 8'd0) begin
            if (rm)      return (of < 20'd4096)  ? E_S0  : E_AB;
            else if (bt) return (of < 20'd32768) ? E_ROM : E_AB;
            else         return e_ext(0);
         end
         if (ri == 8'd1) return (of < 20'd32768) ? E_ROM : E_AB;
         if (ri == 8'd2) return (of < 20'd4096)  ? E_S0  : E_AB;
         if (ri == 8'd3) return (of < 20'd4096)  ? E_S1  : E_AB;
         return E_AB;
      end
      if (bk < 4'd8)   return e_ext(int'(bk));
      if (bk == 4'hF)  return E_PER;
      return E_AB;
   endfunction

   function automatic logic [12:0] actual();
      return {abort_s, sel_periph, sel_ext, sel_sram, sel_rom};
   endfunction

   task automatic check(input string tag);
      logic [12:0] exp;
      exp = model(valid, addr, m_remap, m_boot);
      n_checks++;
      if (actual() !== exp) begin
         n_fail++;
         $display("FAIL %s addr=%h valid=%b act=%h exp=%h", tag, addr, valid,
                  actual(), exp);
      end
   endtask

   // Apply one cycle: drive at negedge, check before the next posedge,
   // then let the write (if any) land on that posedge
   task automatic apply(input logic v, input logic [31:0] a,
                        input logic w_en, input logic w_d, input string tag);
      @(negedge clk);
      valid = v; addr = a; we = w_en; wd = w_d;
      #2;
      check(tag);
      @(posedge clk);
      if (w_en) m_remap = w_d;
   endtask

   task automatic do_reset(input logic b);
      @(negedge clk);
      rst_n = 1'b0; boot_sel = b; we = 1'b0; valid = 1'b0;
      repeat (3) @(posedge clk);
      m_remap = 1'b0; m_boot = b;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] ra;
      void'($urandom(32'd20240611));
      do_reset(1'b1);
      apply(1'b0, 32'h0000_0000, 1'b0, 1'b0, "R10 reset idle");
      apply(1'b0, 32'hF000_0000, 1'b0, 1'b0, "R10 idle periph addr");
      // boot from ROM
      apply(1'b1, 32'h0000_0000, 1'b0, 1'b0, "R5 zero to rom");
      apply(1'b1, 32'h0000_7FFF, 1'b0, 1'b0, "R5 rom top");
      apply(1'b1, 32'h0000_8000, 1'b0, 1'b0, "R5 alias above rom");
      boot_sel = 1'b0;
      apply(1'b1, 32'h0000_0100, 1'b0, 1'b0, "R8 pin change after reset");
      // remap write
      apply(1'b1, 32'h0000_0000, 1'b1, 1'b1, "R9 before write");
      apply(1'b1, 32'h0000_0000, 1'b0, 1'b0, "R7 remap to sram0");
      apply(1'b1, 32'h0000_0FFF, 1'b0, 1'b1, "R9 wdata without enable");
      apply(1'b1, 32'h0000_1000, 1'b0, 1'b0, "R7 alias above sram");
      apply(1'b1, 32'h0010_0000, 1'b0, 1'b0, "R4 rom fixed under remap");
      // reset with boot level 0 while remap was 1
      do_reset(1'b0);
      boot_sel = 1'b1;
      apply(1'b1, 32'h0000_0000, 1'b0, 1'b0, "R9 reset clears remap");
      apply(1'b1, 32'h000F_FFFF, 1'b0, 1'b0, "R6 ext0 window top");
      apply(1'b1, 32'h0004_0000, 1'b1, 1'b1, "R6 ext0 mid");
      apply(1'b1, 32'h0000_0004, 1'b1, 1'b0, "R7 sram0 with boot 0");
      apply(1'b1, 32'h0000_0004, 1'b0, 1'b0, "R9 cleared by write");
      // fixed internal bases
      apply(1'b1, 32'h0010_0000, 1'b0, 1'b0, "R4 rom base");
      apply(1'b1, 32'h0010_7FFF, 1'b0, 1'b0, "R4 rom top");
      apply(1'b1, 32'h0010_8000, 1'b0, 1'b0, "R4 rom over");
      apply(1'b1, 32'h0020_0FFF, 1'b0, 1'b0, "R4 sram0 top");
      apply(1'b1, 32'h0020_1000, 1'b0, 1'b0, "R4 sram0 over");
      apply(1'b1, 32'h0030_0000, 1'b0, 1'b0, "R4 sram1 base");
      apply(1'b1, 32'h0030_1000, 1'b0, 1'b0, "R4 sram1 over");
      apply(1'b1, 32'h0040_0000, 1'b0, 1'b0, "R4 region 4");
      apply(1'b1, 32'h0FF0_0000, 1'b0, 1'b0, "R4 region 255");
      // first-level banks
      for (int b = 1; b < 8; b++)
         apply(1'b1, {4'(b), 28'h123_4567}, 1'b0, 1'b0, "R1 ext bank");
      apply(1'b1, 32'h7FFF_FFFF, 1'b0, 1'b0, "R1 ext7 top");
      apply(1'b1, 32'hF000_0000, 1'b0, 1'b0, "R2 periph base");
      apply(1'b1, 32'hFFFF_FFFC, 1'b0, 1'b0, "R2 periph top");
      for (int b = 8; b < 15; b++)
         apply(1'b1, {4'(b), 28'h0}, 1'b0, 1'b0, "R3 hole bank");
      // random mix, weighted to bank 0 low regions
      for (int i = 0; i < 3000; i++) begin
         ra = $urandom;
         if (ra[0]) ra[31:22] = '0;
         if (ra[1] && ra[2]) ra[19:13] = '0;
         apply(ra[5:3] != 3'd0, ra, ($urandom % 16) == 0, ra[6],
               "R11 random mix");
      end
      do_reset(1'b1);
      apply(1'b1, 32'h0000_1234, 1'b0, 1'b0, "R8 captured boot 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule